// File: doc/BRIEF.md
# Dual-Compare Buffered PWM Channel

This block is a single PWM output channel driven by two 24-bit comparators that watch an external free-running time base. A match on the leading-edge value (compare A) drives the pin to a selectable polarity level; a match on the trailing-edge value (compare B) drives it to the opposite level. Each compare is evaluated only in a cycle where the time base has just stepped, which is signalled by a qualify strobe. A time base that rests on one value therefore matches only once.

The trailing-edge value is double buffered. Software writes it into a holding register. A transfer-mode input decides when the new value reaches the active trailing compare: at once, or at the next leading-edge match. The leading-edge value is a plain level input and always takes effect immediately.

A sticky event flag records trailing matches, or both kinds of match, depending on a flag-mode input. Software clears it with a write-one strobe. Two force strobes let software place the pin at either edge level without touching the flag. Equal and zero compare values give defined constant-level outputs.

Top module: `dual_edge_pwm`

## Requirements
- R1: A qualified compare-A match with compare A nonzero and no simultaneous compare-B match sets `pwmOut` to `edgePol` on the next clock edge.
- R2: A qualified compare-B match on its own sets `pwmOut` to the inverse of `edgePol` on the next clock edge.
- R3: With `xferOnA`=0, a `bWr` pulse loads `bData` into the active trailing compare at the next edge. A later qualified step at that value is then a compare-B match.
- R4: With `xferOnA`=1, a written B value stays in the holding register. The active trailing compare keeps its old value until a qualified compare-A match, and then takes the held value. `regA` changes always apply at once.
- R5: With `flagBoth`=0 only compare-B matches set `flag`. With `flagBoth`=1 both compare-A and compare-B matches set it.
- R6: `forceB` drives `pwmOut` to the inverse of `edgePol`, and `forceA` drives it to `edgePol`. Forces override any match in the same cycle, and `forceB` wins when both are high. Forces never set `flag`.
- R7: A `flagClr` pulse clears `flag` at the next edge. If a set condition occurs in the same cycle, `flag` ends up 1.
- R8: Matches keep toggling `pwmOut` while `flag` stays set.
- R9: When compare A and compare B match in the same qualified cycle, `pwmOut` goes to `edgePol`. This holds for equal nonzero values and for both values zero.
- R10: When `regA` is 0 and compare B is nonzero, a qualified compare-A match drives `pwmOut` to the inverse of `edgePol`.
- R11: With `tbStep` low, no compare can match. `pwmOut` and `flag` then hold their values unless a force or clear is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; `pwmOut`, `flag` and the B registers reset to 0 |
| timeBase | input | 24 | External time base value |
| tbStep | input | 1 | Time base advanced this cycle; qualifies both compares |
| regA | input | 24 | Leading-edge compare value, used at once |
| bWr | input | 1 | Write strobe for the trailing-edge value |
| bData | input | 24 | Trailing-edge value to write |
| xferOnA | input | 1 | 0: B written straight to active; 1: B transferred on A match |
| edgePol | input | 1 | Level produced by a leading-edge match |
| flagBoth | input | 1 | 0: flag on B match only; 1: flag on A and B matches |
| forceA | input | 1 | Force pin to the leading-edge level |
| forceB | input | 1 | Force pin to the trailing-edge level |
| flagClr | input | 1 | Write-one clear of `flag` |
| pwmOut | output | 1 | PWM output level |
| flag | output | 1 | Sticky match flag |

## Verification
Every result is registered once. The effect of inputs that are present during one clock edge, such as a match, force, clear or B write, shows on `pwmOut` and `flag` right after that edge. A B value that is written appears only through the outcome of a later step. The driver changes inputs on the falling edge and lets one rising edge pass. Two time units after that edge it pushes the expected pin and flag levels into a queue. The monitor pops each item and compares it to the outputs at that same point, so every check samples exactly one edge after its stimulus.

// File: rtl/dep_pkg.sv
package dep_pkg;
  localparam int unsigned TB_W = 24;

  typedef struct packed {
    logic drvPol;     // pin goes to edgePol
    logic drvInv;     // pin goes to ~edgePol
    logic setFlag;    // a match event sets the flag
    logic loadDirect; // active B takes bData now
    logic loadHold;   // active B takes holding value
  } dep_strobe_t;
endpackage

// File: rtl/dep_ctrl.sv
module dep_ctrl
  import dep_pkg::*;
#(
  parameter int unsigned W = TB_W
) (
  input  logic [W-1:0] timeBase,
  input  logic         tbStep,
  input  logic [W-1:0] regA,
  input  logic [W-1:0] activeB,
  input  logic         bWr,
  input  logic         xferOnA,
  input  logic         flagBoth,
  input  logic         forceA,
  input  logic         forceB,
  output dep_strobe_t  strb
);
  logic hitA, hitB, aIsZero;

  assign hitA    = tbStep && (timeBase == regA);
  assign hitB    = tbStep && (timeBase == activeB);
  assign aIsZero = (regA == '0);

  always_comb begin
    strb = '0;
    if (forceB) begin
      strb.drvInv = 1'b1;
    end else if (forceA) begin
      strb.drvPol = 1'b1;
    end else if (hitA && hitB) begin
      strb.drvPol = 1'b1;
    end else if (hitA) begin
      if (aIsZero) strb.drvInv = 1'b1;
      else         strb.drvPol = 1'b1;
    end else if (hitB) begin
      strb.drvInv = 1'b1;
    end
    strb.setFlag    = hitB || (flagBoth && hitA);
    strb.loadDirect = bWr && !xferOnA;
    strb.loadHold   = xferOnA && hitA;
  end
endmodule

// File: rtl/dep_datapath.sv
module dep_datapath
  import dep_pkg::*;
#(
  parameter int unsigned W = TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dep_strobe_t  strb,
  input  logic         bWr,
  input  logic [W-1:0] bData,
  input  logic         edgePol,
  input  logic         flagClr,
  output logic [W-1:0] activeB,
  output logic         pinQ,
  output logic         flagQ
);
  logic [W-1:0] holdB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdB   <= '0;
      activeB <= '0;
      pinQ    <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (bWr) holdB <= bData;
      if (strb.loadDirect)    activeB <= bData;
      else if (strb.loadHold) activeB <= holdB;
      if (strb.drvInv)      pinQ <= ~edgePol;
      else if (strb.drvPol) pinQ <= edgePol;
      if (strb.setFlag)  flagQ <= 1'b1;
      else if (flagClr)  flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_edge_pwm.sv
module dual_edge_pwm
  import dep_pkg::*;
#(
  parameter int unsigned W = TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] timeBase,
  input  logic         tbStep,
  input  logic [W-1:0] regA,
  input  logic         bWr,
  input  logic [W-1:0] bData,
  input  logic         xferOnA,
  input  logic         edgePol,
  input  logic         flagBoth,
  input  logic         forceA,
  input  logic         forceB,
  input  logic         flagClr,
  output logic         pwmOut,
  output logic         flag
);
  dep_strobe_t  strb;
  logic [W-1:0] activeB;

  dep_ctrl #(.W(W)) u_ctrl (
    .timeBase(timeBase), .tbStep(tbStep), .regA(regA), .activeB(activeB),
    .bWr(bWr), .xferOnA(xferOnA), .flagBoth(flagBoth),
    .forceA(forceA), .forceB(forceB), .strb(strb)
  );

  dep_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .bWr(bWr), .bData(bData),
    .edgePol(edgePol), .flagClr(flagClr), .activeB(activeB),
    .pinQ(pwmOut), .flagQ(flag)
  );
endmodule

// File: rtl/dep_checker.sv
module dep_checker (
  input logic clk,
  input logic rst_n,
  input logic tbStep,
  input logic edgePol,
  input logic forceA,
  input logic forceB,
  input logic flagClr,
  input logic pwmOut,
  input logic flag
);
  // R6: trailing force wins over everything
  assert_forceb_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    forceB |=> (pwmOut == !$past(edgePol)));

  // R6: leading force alone
  assert_forcea_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (forceA && !forceB) |=> (pwmOut == $past(edgePol)));

  // R6 / R11: without a qualified step the flag cannot rise
  assert_no_flag_without_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbStep && !flag) |=> !flag);

  // R7: clear with no possible set empties the flag
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flagClr && !tbStep) |=> !flag);

  // R11: pin holds without step or force
  assert_pin_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbStep && !forceA && !forceB) |=> $stable(pwmOut));

  // R7: flag persists without clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flagClr) |=> flag);
endmodule

bind dual_edge_pwm dep_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tbStep(tbStep), .edgePol(edgePol),
  .forceA(forceA), .forceB(forceB), .flagClr(flagClr),
  .pwmOut(pwmOut), .flag(flag)
);

// File: tb/dual_edge_pwm_tb.sv
module dual_edge_pwm_tb;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] timeBase = '0, regA = '0, bData = '0;
  logic tbStep = 0, bWr = 0, xferOnA = 0, edgePol = 1, flagBoth = 0;
  logic forceA = 0, forceB = 0, flagClr = 0;
  logic pwmOut, flag;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  typedef struct {
    logic  pin;
    logic  flg;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk; // 125 MHz

  dual_edge_pwm #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .timeBase(timeBase), .tbStep(tbStep),
    .regA(regA), .bWr(bWr), .bData(bData), .xferOnA(xferOnA),
    .edgePol(edgePol), .flagBoth(flagBoth), .forceA(forceA),
    .forceB(forceB), .flagClr(flagClr), .pwmOut(pwmOut), .flag(flag)
  );

  // monitor: pops expectations as they are produced
  initial begin
    forever begin
      wait (sbq.size() > 0);
      begin
        exp_t e;
        e = sbq.pop_front();
        nChecks++;
        if (pwmOut !== e.pin || flag !== e.flg) begin
          nErrors++;
          $display("FAIL %s: pwmOut=%b flag=%b expected pwmOut=%b flag=%b",
                   e.tag, pwmOut, flag, e.pin, e.flg);
        end
      end
    end
  end

  // driver: apply one cycle of stimulus, push expected outputs after the edge
  task automatic cyc(input logic stp, input logic [W-1:0] tb,
                     input logic wr, input logic [W-1:0] bd,
                     input logic fa, input logic fb, input logic clr,
                     input logic ePin, input logic eFlg, input string tag);
    @(negedge clk);
    tbStep = stp; timeBase = tb; bWr = wr; bData = bd;
    forceA = fa; forceB = fb; flagClr = clr;
    @(posedge clk);
    #2;
    sbq.push_back('{pin: ePin, flg: eFlg, tag: tag});
    wait (sbq.size() == 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    regA = 24'd10;
    repeat (3) @(posedge clk);
    #2;
    sbq.push_back('{pin: 1'b0, flg: 1'b0, tag: "reset"});
    wait (sbq.size() == 0);
    @(negedge clk) rst_n = 1;

    // R3: immediate B load, no step
    cyc(0, 24'd5, 1, 24'd20, 0, 0, 0, 0, 0, "R3 write no step");
    cyc(1, 24'd10, 0, 0, 0, 0, 0, 1, 0, "R1 A match, R5 no flag in mode0");
    cyc(1, 24'd20, 0, 0, 0, 0, 0, 0, 1, "R2/R3 B match new value");
    cyc(1, 24'd10, 0, 0, 0, 0, 0, 1, 1, "R8 pulses with flag set");
    cyc(0, 24'd10, 0, 0, 0, 0, 1, 1, 0, "R7 clear");
    cyc(1, 24'd20, 0, 0, 0, 0, 1, 0, 1, "R7 set beats clear");
    cyc(0, 24'd0, 0, 0, 0, 0, 1, 0, 0, "R7 clear again");
    cyc(0, 24'd10, 0, 0, 0, 0, 0, 0, 0, "R11 no step no match");

    // R4: deferred transfer
    @(negedge clk) xferOnA = 1;
    cyc(0, 24'd5, 1, 24'd30, 0, 0, 0, 0, 0, "R4 held write");
    cyc(1, 24'd30, 0, 0, 0, 0, 0, 0, 0, "R4 held value not active");
    cyc(1, 24'd10, 0, 0, 0, 0, 0, 1, 0, "R4 A match transfers");
    cyc(1, 24'd20, 0, 0, 0, 0, 0, 1, 0, "R4 old B gone");
    cyc(1, 24'd30, 0, 0, 0, 0, 0, 0, 1, "R4 new B matches");

    // R5: flag on both
    @(negedge clk) flagBoth = 1;
    cyc(0, 24'd0, 0, 0, 0, 0, 1, 0, 0, "R5 clear");
    cyc(1, 24'd10, 0, 0, 0, 0, 0, 1, 1, "R5 A match flags");

    // R6: forces
    cyc(0, 24'd0, 0, 0, 0, 0, 1, 1, 0, "R6 clear");
    cyc(0, 24'd0, 0, 0, 0, 1, 0, 0, 0, "R6 forceB no flag");
    cyc(0, 24'd0, 0, 0, 1, 0, 0, 1, 0, "R6 forceA no flag");
    cyc(0, 24'd0, 0, 0, 1, 1, 0, 0, 0, "R6 both forces B wins");
    cyc(1, 24'd30, 0, 0, 1, 0, 0, 1, 1, "R6 force beats B match");

    // R9: equal nonzero values
    @(negedge clk) begin xferOnA = 0; regA = 24'd40; end
    cyc(0, 24'd0, 1, 24'd40, 0, 1, 1, 0, 0, "R9 setup");
    cyc(1, 24'd40, 0, 0, 0, 0, 0, 1, 1, "R9 equal values to edgePol");

    // R10: A zero alone
    @(negedge clk) regA = 24'd0;
    cyc(0, 24'd0, 0, 0, 1, 0, 1, 1, 0, "R10 setup");
    cyc(1, 24'd0, 0, 0, 0, 0, 0, 0, 1, "R10 zero A gives inverse");

    // R9: both zero
    cyc(0, 24'd0, 1, 24'd0, 0, 0, 0, 0, 1, "R9 write B zero");
    cyc(1, 24'd0, 0, 0, 0, 0, 0, 1, 1, "R9 both zero to edgePol");
    @(negedge clk) edgePol = 0;
    cyc(1, 24'd0, 0, 0, 0, 0, 0, 0, 1, "R9 both zero low polarity");

    // R2 with low polarity
    @(negedge clk) regA = 24'd5;
    cyc(1, 24'd0, 0, 0, 0, 0, 0, 1, 1, "R2 B alone low polarity");
    cyc(1, 24'd5, 0, 0, 0, 0, 0, 0, 1, "R1 A match low polarity");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule